// File: doc/BRIEF.md
# Thermal Operating-Point Arbiter

This block picks the performance operating point a core should run at. Points are numbered from 0 (slowest clock) upward to `NUM_PTS-1` (fastest). Software posts load-based requests. A thermal episode forces the target down, either in one jump to point 0 or, in adaptive mode, one step per evaluation interval. In adaptive mode the target then climbs back one step after a run of cool intervals. During an episode, a software request that is slower than the thermal limit takes effect. A faster one is parked and only applied when the episode ends.

The block also drives a clock-modulation request. When only modulation is enabled, the request follows the hot flag directly. When both mechanisms are enabled, the operating-point path has priority. Modulation is then added only if the force bit is set, the floor point has been reached and settled, and the part is still hot. A fixed settle counter stands in for the time a transition takes. No new target is committed while it runs.

Top module: `thermal_opp_arbiter`

## Requirements
- R1: Reset state: `tgt_idx` is `NUM_PTS-1`, and `xfer_stb` is 0.
- R2: With no thermal episode, a request on `sw_req_idx` with `sw_req_vld` high is latched on that edge. It becomes `tgt_idx` on the next edge at which the settle counter is idle.
- R3: After a commit, no new commit happens for `SETTLE_CYC` clock cycles. The next commit comes at the earliest `SETTLE_CYC+1` edges later.
- R4: With `opp_en` high, `adapt_en` low and `therm_hot` high, an episode starts on the next edge and the target is driven to index 0.
- R5: When an episode ends, the target returns to the most recent software request, including one received during the episode. A fixed episode ends on the first edge at which `therm_hot` or `opp_en` is low.
- R6: During an episode, a software request above the thermal limit index is held and does not change `tgt_idx`.
- R7: During an episode, a software request below the thermal limit index is committed without waiting for the episode to end.
- R8: With `opp_en` low, `clkmod_req` equals `clkmod_en & therm_hot` in the same cycle.
- R9: With `opp_en` high and `force_both` low, `clkmod_req` stays 0.
- R10: With `opp_en`, `clkmod_en` and `force_both` high, `clkmod_req` rises only while hot, in an episode, with `tgt_idx` at 0 and the settle counter idle.
- R11: In adaptive mode, an episode starts with the limit one below the current target. The limit then drops by one on every evaluation tick (every `EVAL_CYC` cycles) while hot, saturating at 0.
- R12: In adaptive mode, after `COOL_N` consecutive cool ticks the limit rises by one. When that rise would reach the software request, the episode ends instead.
- R13: `xfer_stb` is high for exactly the cycles in which `tgt_idx` has just taken a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req_vld | input | 1 | Software request strobe |
| sw_req_idx | input | IDX_W | Requested operating-point index |
| therm_hot | input | 1 | Over-temperature flag |
| opp_en | input | 1 | Enable for operating-point reduction |
| clkmod_en | input | 1 | Enable for clock-modulation throttling |
| force_both | input | 1 | Add modulation when the floor point is not enough |
| adapt_en | input | 1 | Adaptive stepping instead of a jump to 0 |
| tgt_idx | output | IDX_W | Committed target operating point |
| xfer_stb | output | 1 | One-cycle pulse on each new commit |
| clkmod_req | output | 1 | Request to the clock-modulation throttle |

## Verification
The latency of each result differs. A software request changes `tgt_idx` two edges after it is driven when the settle counter is idle: one edge to latch it, one to commit it. An episode needs one edge to start and one more to commit. `clkmod_req` is combinational on `therm_hot` and the enables, so it is due in the same cycle. The bench model updates its state at the same clock edges as the design and compares all three outputs shortly after each falling edge, so every result is checked in the exact cycle it is due. Spot checks after long waits confirm the settled values for each scenario.

// File: rtl/tao_pkg.sv
package tao_pkg;
  typedef enum logic [1:0] {
    EP_IDLE  = 2'd0,
    EP_FIXED = 2'd1,
    EP_ADAPT = 2'd2
  } ep_state_e;
endpackage

// File: rtl/tao_eval_timer.sv
module tao_eval_timer #(
  parameter int EVAL_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (EVAL_CYC <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(EVAL_CYC);
      localparam logic [CW-1:0] LAST = CW'(EVAL_CYC - 1);
      logic [CW-1:0] cnt_q, cnt_d;
      always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
      assign tick = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/tao_episode_ctl.sv
module tao_episode_ctl
  import tao_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int COOL_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hot,
  input  logic             opp_en,
  input  logic             adapt_en,
  input  logic             tick,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [IDX_W-1:0] sw_idx,
  output logic             ep_active,
  output logic [IDX_W-1:0] lim_idx
);
  localparam int CLW = (COOL_N < 2) ? 1 : $clog2(COOL_N);
  localparam logic [CLW-1:0] COOL_LAST = CLW'(COOL_N - 1);

  ep_state_e      st_q, st_d;
  logic [IDX_W-1:0] lim_q, lim_d;
  logic [CLW-1:0]   cool_q, cool_d;
  logic             upd_en;
  logic [IDX_W:0]   lim_up;

  assign lim_up = {1'b0, lim_q} + 1'b1;

  always_comb begin
    st_d   = st_q;
    lim_d  = lim_q;
    cool_d = cool_q;
    case (st_q)
      EP_IDLE: begin
        if (opp_en && hot) begin
          if (adapt_en) begin
            st_d   = EP_ADAPT;
            lim_d  = (cur_idx != '0) ? cur_idx - 1'b1 : '0;
            cool_d = '0;
          end else begin
            st_d  = EP_FIXED;
            lim_d = '0;
          end
        end
      end
      EP_FIXED: begin
        if (!(opp_en && hot)) st_d = EP_IDLE;
      end
      EP_ADAPT: begin
        if (!opp_en) begin
          st_d = EP_IDLE;
        end else if (tick) begin
          if (hot) begin
            lim_d  = (lim_q != '0) ? lim_q - 1'b1 : '0;
            cool_d = '0;
          end else if (cool_q == COOL_LAST) begin
            cool_d = '0;
            if (lim_up >= {1'b0, sw_idx}) st_d = EP_IDLE;
            else                          lim_d = lim_up[IDX_W-1:0];
          end else begin
            cool_d = cool_q + 1'b1;
          end
        end
      end
      default: st_d = EP_IDLE;
    endcase
  end

  assign upd_en = (st_d != st_q) || (lim_d != lim_q) || (cool_d != cool_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= EP_IDLE;
      lim_q  <= '0;
      cool_q <= '0;
    end else if (upd_en) begin
      st_q   <= st_d;
      lim_q  <= lim_d;
      cool_q <= cool_d;
    end
  end

  assign ep_active = (st_q != EP_IDLE);
  assign lim_idx   = lim_q;
endmodule

// File: rtl/tao_commit.sv
module tao_commit #(
  parameter int IDX_W      = 3,
  parameter int SETTLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] want_idx,
  output logic [IDX_W-1:0] cur_idx,
  output logic             stb,
  output logic             settled
);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SLOAD = SW'(SETTLE_CYC);
  localparam logic [IDX_W-1:0] TOP = {IDX_W{1'b1}};

  logic [IDX_W-1:0] cur_q, cur_d;
  logic [SW-1:0]    set_q, set_d;
  logic             stb_q, commit;

  assign commit = (set_q == '0) && (want_idx != cur_q);

  always_comb begin
    cur_d = cur_q;
    set_d = (set_q != '0) ? set_q - 1'b1 : '0;
    if (commit) begin
      cur_d = want_idx;
      set_d = SLOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= TOP;
      set_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= commit;
      if (commit || (set_q != '0)) set_q <= set_d;
      if (commit)                  cur_q <= cur_d;
    end
  end

  assign cur_idx = cur_q;
  assign stb     = stb_q;
  assign settled = (set_q == '0);
endmodule

// File: rtl/thermal_opp_arbiter.sv
module thermal_opp_arbiter #(
  parameter int NUM_PTS    = 8,
  parameter int SETTLE_CYC = 4,
  parameter int EVAL_CYC   = 16,
  parameter int COOL_N     = 3,
  localparam int IDX_W     = $clog2(NUM_PTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_req_vld,
  input  logic [IDX_W-1:0] sw_req_idx,
  input  logic             therm_hot,
  input  logic             opp_en,
  input  logic             clkmod_en,
  input  logic             force_both,
  input  logic             adapt_en,
  output logic [IDX_W-1:0] tgt_idx,
  output logic             xfer_stb,
  output logic             clkmod_req
);
  localparam logic [IDX_W-1:0] TOP = {IDX_W{1'b1}};

  logic [IDX_W-1:0] sw_q;
  logic [IDX_W-1:0] lim_idx, want_idx, cur_idx;
  logic             tick, ep_active, settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sw_q <= TOP;
    else if (sw_req_vld) sw_q <= sw_req_idx;
  end

  tao_eval_timer #(.EVAL_CYC(EVAL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  tao_episode_ctl #(.IDX_W(IDX_W), .COOL_N(COOL_N)) u_episode (
    .clk(clk), .rst_n(rst_n), .hot(therm_hot), .opp_en(opp_en),
    .adapt_en(adapt_en), .tick(tick), .cur_idx(cur_idx), .sw_idx(sw_q),
    .ep_active(ep_active), .lim_idx(lim_idx)
  );

  always_comb begin
    want_idx = sw_q;
    if (ep_active && (lim_idx < sw_q)) want_idx = lim_idx;
  end

  tao_commit #(.IDX_W(IDX_W), .SETTLE_CYC(SETTLE_CYC)) u_commit (
    .clk(clk), .rst_n(rst_n), .want_idx(want_idx),
    .cur_idx(cur_idx), .stb(xfer_stb), .settled(settled)
  );

  assign tgt_idx    = cur_idx;
  assign clkmod_req = clkmod_en && therm_hot &&
                      (!opp_en || (force_both && ep_active && settled && (cur_idx == '0)));
endmodule

// File: rtl/tao_arbiter_chk.sv
module tao_arbiter_chk #(
  parameter int IDX_W      = 3,
  parameter int SETTLE_CYC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             therm_hot,
  input logic             opp_en,
  input logic             clkmod_en,
  input logic             force_both,
  input logic [IDX_W-1:0] tgt_idx,
  input logic             xfer_stb,
  input logic             clkmod_req
);
  localparam int GW = $clog2(SETTLE_CYC + 1) + 1;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gap_q <= GW'(SETTLE_CYC);
    else if (xfer_stb)                 gap_q <= '0;
    else if (gap_q < GW'(SETTLE_CYC))  gap_q <= gap_q + 1'b1;
  end

  a_r3_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb |-> (gap_q >= GW'(SETTLE_CYC)));
  a_r13_stb_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tgt_idx) |-> xfer_stb);
  a_r13_change_on_stb: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb |-> !$stable(tgt_idx));
  a_r8_mod_alone: assert property (@(posedge clk) disable iff (!rst_n)
    !opp_en |-> (clkmod_req == (clkmod_en && therm_hot)));
  a_r9_no_mod_unforced: assert property (@(posedge clk) disable iff (!rst_n)
    (opp_en && !force_both) |-> !clkmod_req);
  a_r10_mod_at_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (opp_en && clkmod_req) |-> (tgt_idx == '0 && therm_hot));
endmodule

bind thermal_opp_arbiter tao_arbiter_chk #(.IDX_W(IDX_W), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .therm_hot(therm_hot), .opp_en(opp_en),
  .clkmod_en(clkmod_en), .force_both(force_both), .tgt_idx(tgt_idx),
  .xfer_stb(xfer_stb), .clkmod_req(clkmod_req)
);

// File: tb/thermal_opp_arbiter_tb.sv
`timescale 1ns/1ps
module thermal_opp_arbiter_tb;
  localparam int NP = 8, ST = 3, EV = 6, CN = 2, W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_vld = 1'b0, hot = 1'b0, oen = 1'b1, men = 1'b1, frc = 1'b0, aen = 1'b0;
  logic [W-1:0] sw_idx = '0;
  logic [W-1:0] tgt;
  logic stb, mreq;

  int total = 0, bad = 0, cyc = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  thermal_opp_arbiter #(.NUM_PTS(NP), .SETTLE_CYC(ST), .EVAL_CYC(EV), .COOL_N(CN)) u_dut (
    .clk(clk), .rst_n(rst_n), .sw_req_vld(sw_vld), .sw_req_idx(sw_idx),
    .therm_hot(hot), .opp_en(oen), .clkmod_en(men), .force_both(frc),
    .adapt_en(aen), .tgt_idx(tgt), .xfer_stb(stb), .clkmod_req(mreq)
  );

  // behavioural reference: ep 0 none, 1 jump-to-floor, 2 stepping
  int m_cur, m_sw, m_set, m_ep, m_lim, m_cool, m_ev, m_stb;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur = NP - 1; m_sw = NP - 1; m_set = 0; m_ep = 0;
      m_lim = 0; m_cool = 0; m_ev = 0; m_stb = 0;
    end else begin
      int want, n_ep, n_lim, n_cool;
      bit tk;
      tk = (m_ev == EV - 1);
      want = (m_ep != 0 && m_lim < m_sw) ? m_lim : m_sw;
      n_ep = m_ep; n_lim = m_lim; n_cool = m_cool;
      if (m_ep == 0) begin
        if (oen && hot) begin
          if (aen) begin n_ep = 2; n_lim = (m_cur > 0) ? m_cur - 1 : 0; n_cool = 0; end
          else begin n_ep = 1; n_lim = 0; end
        end
      end else if (m_ep == 1) begin
        if (!(oen && hot)) n_ep = 0;
      end else begin
        if (!oen) n_ep = 0;
        else if (tk) begin
          if (hot) begin n_lim = (m_lim > 0) ? m_lim - 1 : 0; n_cool = 0; end
          else if (m_cool + 1 >= CN) begin
            n_cool = 0;
            if (m_lim + 1 >= m_sw) n_ep = 0; else n_lim = m_lim + 1;
          end else n_cool = m_cool + 1;
        end
      end
      if (m_set == 0 && want != m_cur) begin
        m_cur = want; m_set = ST; m_stb = 1;
      end else begin
        m_stb = 0;
        if (m_set > 0) m_set = m_set - 1;
      end
      m_ep = n_ep; m_lim = n_lim; m_cool = n_cool;
      if (sw_vld) m_sw = sw_idx;
      m_ev = tk ? 0 : m_ev + 1;
    end
  end

  task automatic chk(string t, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at cycle %0d", t, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      bit em;
      em = men && hot && (!oen || (frc && m_ep != 0 && m_cur == 0 && m_set == 0));
      chk(tag, int'(tgt), m_cur);
      chk("R13", int'(stb), m_stb);
      chk(tag, int'(mreq), int'(em));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req(int idx);
    @(negedge clk); sw_vld = 1'b1; sw_idx = W'(idx);
    @(negedge clk); sw_vld = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    #1; chk("R1", int'(tgt), NP - 1); chk("R1", int'(stb), 0);
    // R2 / R3: back-to-back requests against the settle window
    tag = "R2"; req(3); idle(8); chk("R2", int'(tgt), 3);
    tag = "R3"; req(5); req(1); idle(10); chk("R3", int'(tgt), 1);
    // R4 / R9: jump to floor, no modulation without force
    tag = "R4"; @(negedge clk); hot = 1'b1; idle(12);
    chk("R4", int'(tgt), 0); chk("R9", int'(mreq), 0);
    // R6: faster request parked
    tag = "R6"; req(6); idle(8); chk("R6", int'(tgt), 0);
    // R5: restore on cool
    tag = "R5"; @(negedge clk); hot = 1'b0; idle(10); chk("R5", int'(tgt), 6);
    // R8: modulation alone
    tag = "R8"; @(negedge clk); oen = 1'b0; hot = 1'b1; idle(4);
    chk("R8", int'(mreq), 1); chk("R8", int'(tgt), 6);
    @(negedge clk); hot = 1'b0; #1; chk("R8", int'(mreq), 0);
    // R10: forced modulation once floor settled
    tag = "R10"; @(negedge clk); oen = 1'b1; frc = 1'b1; hot = 1'b1; idle(15);
    chk("R10", int'(mreq), 1); chk("R10", int'(tgt), 0);
    @(negedge clk); hot = 1'b0; idle(10); chk("R10", int'(mreq), 0);
    // R11 / R7 / R12: adaptive stepping
    tag = "R11"; @(negedge clk); frc = 1'b0; aen = 1'b1; req(7); idle(8);
    @(negedge clk); hot = 1'b1; idle(12);
    tag = "R7"; req(2); idle(8); chk("R7", int'(tgt), 2);
    tag = "R11"; req(7); idle(60); chk("R11", int'(tgt), 0);
    tag = "R12"; @(negedge clk); hot = 1'b0; idle(150); chk("R12", int'(tgt), 7);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule